// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block answers the question "how fast does this derived clock run?" in hertz, from the configuration fields that shape a clock tree. It models a fixed 24 MHz reference, a system PLL that multiplies the reference by 22 or by 20, two fractional phase dividers fed from the PLL, a four-way source multiplexer, and a chain of three integer post-dividers. These produce a bus clock, an I/O clock and a timer clock. Fixed answers are returned for the raw reference, the reference divided by eight and a low-speed 32 kHz source.

A requester presents a clock identifier with a valid strobe while the block is idle. The block captures the identifier and all configuration fields at that moment. It steps through the chain using one shared sequential unsigned divider, then presents a 32-bit frequency with a one-cycle done strobe. All intermediate values are kept at 64 bits, and the result is the low 32 bits of the final value. A zero fraction on a selected phase divider is reported through an error flag instead of being divided.

Top module: `clkfreq_calc`

## Requirements
- R1: After reset, req_ready is 1, and done, freq and err are all 0.
- R2: The PLL value is 24,000,000 times 22 when pll_hi_sel is 1, and 24,000,000 times 20 when it is 0. With src_sel 0 the PLL value is the peripheral source.
- R3: A phase divider yields the PLL value times 18, divided by its fraction field and truncated. src_sel 1 selects phase divider 2 (phase2_frac) and src_sel 2 selects phase divider 0 (phase0_frac).
- R4: src_sel 3 selects the truncated phase divider 2 result, halved with truncation.
- R5: Identifier 1 returns the I/O clock. The bus clock is the source divided by (bus_div + 1), and the I/O clock is the bus clock divided by (io_div + 1), each step truncating.
- R6: Identifier 2 returns the timer clock, which is the I/O clock divided by (tmr_div + 1), truncating.
- R7: Identifier 3 returns the LOW_HZ parameter (default 32768), identifier 4 returns 24,000,000 and identifier 5 returns 3,000,000.
- R8: Identifier 0 (none) and the unused identifiers 6 and 7 return 0 with err 0.
- R9: For identifier 1 or 2, a selected fraction field of 0 with src_sel not 0 returns 0 with err 1. A zero fraction that src_sel does not select has no effect. err is cleared by the next accepted request.
- R10: A request is accepted only when req_ready is 1. req_ready falls after acceptance and returns with done. done is high for exactly one cycle per accepted request. A valid raised while busy is ignored.
- R11: Configuration fields are captured on acceptance. Changes to them while the request is in progress do not alter its result.
- R12: The result is the low 32 bits of the 64-bit final value when that value exceeds 32 bits.
- R13: freq and err change only in the cycle in which done is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_id | input | 3 | Clock identifier (0 none, 1 I/O, 2 timer, 3 low, 4 reference, 5 reference/8) |
| req_ready | output | 1 | Idle; a request is accepted |
| pll_hi_sel | input | 1 | PLL multiplier select: 1 gives x22, 0 gives x20 |
| src_sel | input | 2 | Peripheral source select |
| phase0_frac | input | FRAC_W | Fraction of phase divider 0 |
| phase2_frac | input | FRAC_W | Fraction of phase divider 2 |
| bus_div | input | BUS_W | Bus post-divider field |
| io_div | input | IO_W | I/O post-divider field |
| tmr_div | input | TMR_W | Timer post-divider field |
| done | output | 1 | One-cycle result strobe |
| freq | output | 32 | Computed frequency in Hz |
| err | output | 1 | Zero fraction on the selected phase divider |

## Verification
The checker assumes that req_valid and req_id are known at every clock edge after reset. It also assumes that a request's outcome is judged only at its done strobe, so no protocol rule is placed on the requester while the block is busy. The stimulus drives every input on the falling edge. It holds req_valid for one cycle per request, and raises it while busy only on purpose, to show that such a request is dropped. Field values stay within their declared widths, and phase fractions of zero appear only in the scenarios built to test the error path.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;

  localparam longint unsigned REF_HZ     = 64'd24000000;
  localparam longint unsigned MULT_HI    = 64'd22;
  localparam longint unsigned MULT_LO    = 64'd20;
  localparam longint unsigned PHASE_MULT = 64'd18;
  localparam longint unsigned REF_DIV    = 64'd8;

  localparam logic [2:0] ID_NONE  = 3'd0;
  localparam logic [2:0] ID_IO    = 3'd1;
  localparam logic [2:0] ID_TMR   = 3'd2;
  localparam logic [2:0] ID_LOW   = 3'd3;
  localparam logic [2:0] ID_REF   = 3'd4;
  localparam logic [2:0] ID_REF8  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PHASE,
    ST_BUS,
    ST_IO,
    ST_TMR,
    ST_DONE
  } stage_t;

endpackage

// File: rtl/clkfreq_divider.sv
module clkfreq_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;
  logic             step_en;

  always_comb begin
    trial   = {rem_q, quo_q[NUM_W-1]};
    diff    = trial - {1'b0, den_q};
    fits    = trial >= {1'b0, den_q};
    step_en = start || (cnt_q != '0);
    quo_d   = quo_q;
    rem_d   = rem_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (start) begin
      quo_d = num;
      rem_d = '0;
      den_d = den;
      cnt_d = CNT_W'(NUM_W);
    end else if (cnt_q != '0) begin
      quo_d  = {quo_q[NUM_W-2:0], fits};
      rem_d  = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (step_en) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
        den_q <= den_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

endmodule

// File: rtl/clkfreq_cfg_hold.sv
module clkfreq_cfg_hold
  import clkfreq_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int BUS_W  = 3,
  parameter int IO_W   = 2,
  parameter int TMR_W  = 6,
  parameter int DEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [2:0]        id_in,
  input  logic [1:0]        src_in,
  input  logic [FRAC_W-1:0] phase0_in,
  input  logic [FRAC_W-1:0] phase2_in,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic [IO_W-1:0]   io_in,
  input  logic [TMR_W-1:0]  tmr_in,
  input  stage_t            stage,
  output logic [2:0]        id_q,
  output logic [1:0]        src_q,
  output logic [DEN_W-1:0]  den
);

  logic [FRAC_W-1:0] phase0_q, phase2_q;
  logic [BUS_W-1:0]  bus_q;
  logic [IO_W-1:0]   io_q;
  logic [TMR_W-1:0]  tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q     <= '0;
      src_q    <= '0;
      phase0_q <= '0;
      phase2_q <= '0;
      bus_q    <= '0;
      io_q     <= '0;
      tmr_q    <= '0;
    end else if (cap_en) begin
      id_q     <= id_in;
      src_q    <= src_in;
      phase0_q <= phase0_in;
      phase2_q <= phase2_in;
      bus_q    <= bus_in;
      io_q     <= io_in;
      tmr_q    <= tmr_in;
    end
  end

  always_comb begin
    unique case (stage)
      ST_PHASE: den = (src_q == 2'd2) ? DEN_W'(phase0_q) : DEN_W'(phase2_q);
      ST_BUS:   den = DEN_W'(bus_q) + DEN_W'(1);
      ST_IO:    den = DEN_W'(io_q) + DEN_W'(1);
      ST_TMR:   den = DEN_W'(tmr_q) + DEN_W'(1);
      default:  den = DEN_W'(1);
    endcase
  end

endmodule

// File: rtl/clkfreq_seq.sv
module clkfreq_seq
  import clkfreq_pkg::*;
#(
  parameter int          FRAC_W = 6,
  parameter int          ACC_W  = 64,
  parameter int          OUT_W  = 32,
  parameter int unsigned LOW_HZ = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_id,
  input  logic              pll_hi_sel,
  input  logic [1:0]        src_sel,
  input  logic [FRAC_W-1:0] phase0_frac,
  input  logic [FRAC_W-1:0] phase2_frac,
  input  logic [2:0]        id_q,
  input  logic [1:0]        src_q,
  input  logic              div_done,
  input  logic [ACC_W-1:0]  div_quo,
  output stage_t            stage,
  output logic              cap_en,
  output logic              div_start,
  output logic [ACC_W-1:0]  div_num,
  output logic              req_ready,
  output logic              done,
  output logic [OUT_W-1:0]  freq,
  output logic              err
);

  localparam logic [ACC_W-1:0] PLL_HI   = ACC_W'(REF_HZ * MULT_HI);
  localparam logic [ACC_W-1:0] PLL_LO   = ACC_W'(REF_HZ * MULT_LO);
  localparam logic [ACC_W-1:0] REF_VAL  = ACC_W'(REF_HZ);
  localparam logic [ACC_W-1:0] REF8_VAL = ACC_W'(REF_HZ / REF_DIV);
  localparam logic [ACC_W-1:0] LOW_VAL  = ACC_W'(LOW_HZ);
  localparam logic [ACC_W-1:0] PH_MULT  = ACC_W'(PHASE_MULT);

  stage_t            state_q, state_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              ferr_q, ferr_d;
  logic              launched_q, launched_d;
  logic              done_q, done_d;
  logic [OUT_W-1:0]  freq_q, freq_d;
  logic              err_q, err_d;
  logic              accept;
  logic              in_div;
  logic              out_en;
  logic [ACC_W-1:0]  pll_val;
  logic [FRAC_W-1:0] live_frac;

  always_comb begin
    accept    = req_valid && (state_q == ST_IDLE);
    in_div    = (state_q == ST_PHASE) || (state_q == ST_BUS) ||
                (state_q == ST_IO) || (state_q == ST_TMR);
    div_start = in_div && !launched_q;
    pll_val   = pll_hi_sel ? PLL_HI : PLL_LO;
    live_frac = (src_sel == 2'd2) ? phase0_frac : phase2_frac;
    out_en    = (state_q == ST_DONE);

    state_d    = state_q;
    acc_d      = acc_q;
    ferr_d     = ferr_q;
    launched_d = launched_q;
    done_d     = 1'b0;
    freq_d     = freq_q;
    err_d      = err_q;

    if (div_start) launched_d = 1'b1;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          ferr_d  = 1'b0;
          state_d = ST_DONE;
          unique case (req_id)
            ID_IO, ID_TMR: begin
              if (src_sel == 2'd0) begin
                acc_d   = pll_val;
                state_d = ST_BUS;
              end else if (live_frac == '0) begin
                acc_d  = '0;
                ferr_d = 1'b1;
              end else begin
                acc_d   = pll_val * PH_MULT;
                state_d = ST_PHASE;
              end
            end
            ID_LOW:  acc_d = LOW_VAL;
            ID_REF:  acc_d = REF_VAL;
            ID_REF8: acc_d = REF8_VAL;
            default: acc_d = '0;
          endcase
        end
      end
      ST_PHASE: begin
        if (div_done) begin
          launched_d = 1'b0;
          acc_d      = (src_q == 2'd3) ? (div_quo >> 1) : div_quo;
          state_d    = ST_BUS;
        end
      end
      ST_BUS: begin
        if (div_done) begin
          launched_d = 1'b0;
          acc_d      = div_quo;
          state_d    = ST_IO;
        end
      end
      ST_IO: begin
        if (div_done) begin
          launched_d = 1'b0;
          acc_d      = div_quo;
          state_d    = (id_q == ID_TMR) ? ST_TMR : ST_DONE;
        end
      end
      ST_TMR: begin
        if (div_done) begin
          launched_d = 1'b0;
          acc_d      = div_quo;
          state_d    = ST_DONE;
        end
      end
      ST_DONE: begin
        freq_d  = acc_q[OUT_W-1:0];
        err_d   = ferr_q;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      acc_q      <= '0;
      ferr_q     <= 1'b0;
      launched_q <= 1'b0;
      done_q     <= 1'b0;
      freq_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      acc_q      <= acc_d;
      ferr_q     <= ferr_d;
      launched_q <= launched_d;
      done_q     <= done_d;
      if (out_en) begin
        freq_q <= freq_d;
        err_q  <= err_d;
      end
    end
  end

  assign stage     = state_q;
  assign cap_en    = accept;
  assign div_num   = acc_q;
  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign freq      = freq_q;
  assign err       = err_q;

endmodule

// File: rtl/clkfreq_calc.sv
module clkfreq_calc
  import clkfreq_pkg::*;
#(
  parameter int          FRAC_W = 6,
  parameter int          BUS_W  = 3,
  parameter int          IO_W   = 2,
  parameter int          TMR_W  = 6,
  parameter int          ACC_W  = 64,
  parameter int unsigned LOW_HZ = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_id,
  output logic              req_ready,
  input  logic              pll_hi_sel,
  input  logic [1:0]        src_sel,
  input  logic [FRAC_W-1:0] phase0_frac,
  input  logic [FRAC_W-1:0] phase2_frac,
  input  logic [BUS_W-1:0]  bus_div,
  input  logic [IO_W-1:0]   io_div,
  input  logic [TMR_W-1:0]  tmr_div,
  output logic              done,
  output logic [31:0]       freq,
  output logic              err
);

  localparam int W_A   = (FRAC_W > TMR_W) ? FRAC_W : TMR_W;
  localparam int W_B   = (BUS_W > IO_W) ? BUS_W : IO_W;
  localparam int DEN_W = ((W_A > W_B) ? W_A : W_B) + 1;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  stage_t           stage;
  logic             cap_en;
  logic             div_start;
  logic             div_done;
  logic [ACC_W-1:0] div_num;
  logic [ACC_W-1:0] div_quo;
  logic [DEN_W-1:0] den;
  logic [2:0]       id_q;
  logic [1:0]       src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  clkfreq_cfg_hold #(
    .FRAC_W(FRAC_W), .BUS_W(BUS_W), .IO_W(IO_W), .TMR_W(TMR_W), .DEN_W(DEN_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cap_en(cap_en),
    .id_in(req_id), .src_in(src_sel),
    .phase0_in(phase0_frac), .phase2_in(phase2_frac),
    .bus_in(bus_div), .io_in(io_div), .tmr_in(tmr_div),
    .stage(stage), .id_q(id_q), .src_q(src_q), .den(den)
  );

  clkfreq_seq #(
    .FRAC_W(FRAC_W), .ACC_W(ACC_W), .OUT_W(32), .LOW_HZ(LOW_HZ)
  ) i_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_id(req_id),
    .pll_hi_sel(pll_hi_sel), .src_sel(src_sel),
    .phase0_frac(phase0_frac), .phase2_frac(phase2_frac),
    .id_q(id_q), .src_q(src_q),
    .div_done(div_done), .div_quo(div_quo),
    .stage(stage), .cap_en(cap_en),
    .div_start(div_start), .div_num(div_num),
    .req_ready(req_ready), .done(done), .freq(freq), .err(err)
  );

  clkfreq_divider #(
    .NUM_W(ACC_W), .DEN_W(DEN_W)
  ) i_div (
    .clk(clk), .rst_n(rst_sync_n), .start(div_start),
    .num(div_num), .den(den), .done(div_done), .quo(div_quo)
  );

endmodule

// File: rtl/clkfreq_calc_chk.sv
module clkfreq_calc_chk
  import clkfreq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_id,
  input logic        req_ready,
  input logic        done,
  input logic [31:0] freq,
  input logic        err
);

  logic [2:0] seen_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen_id <= '0;
    else if (req_valid && req_ready) seen_id <= req_id;
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r13_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(freq) && $stable(err))));

  a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (seen_id == ID_NONE || seen_id > ID_REF8)) |-> (freq == 32'd0 && !err));

  a_r7_ref_const: assert property (@(posedge clk) disable iff (!rst_n)
    (done && seen_id == ID_REF) |-> (freq == 32'd24000000));

  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (freq == 32'd0));

endmodule

bind clkfreq_calc clkfreq_calc_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_id(req_id),
  .req_ready(req_ready), .done(done), .freq(freq), .err(err)
);

// File: tb/test_clkfreq_calc.sv
module test_clkfreq_calc;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WAIT_MAX   = 1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_id;
  logic        req_ready;
  logic        pll_hi_sel;
  logic [1:0]  src_sel;
  logic [5:0]  phase0_frac;
  logic [5:0]  phase2_frac;
  logic [2:0]  bus_div;
  logic [1:0]  io_div;
  logic [5:0]  tmr_div;
  logic        done;
  logic [31:0] freq;
  logic        err;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkfreq_calc i_clkfreq_calc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_ready(req_ready), .pll_hi_sel(pll_hi_sel), .src_sel(src_sel),
    .phase0_frac(phase0_frac), .phase2_frac(phase2_frac),
    .bus_div(bus_div), .io_div(io_div), .tmr_div(tmr_div),
    .done(done), .freq(freq), .err(err)
  );

  function automatic logic [32:0] model(input logic [2:0] id);
    logic [63:0] v;
    logic [63:0] f;
    logic        e;
    e = 1'b0;
    v = 64'd0;
    case (id)
      3'd1, 3'd2: begin
        v = 64'd24000000 * (pll_hi_sel ? 64'd22 : 64'd20);
        if (src_sel != 2'd0) begin
          f = (src_sel == 2'd2) ? 64'(phase0_frac) : 64'(phase2_frac);
          if (f == 0) e = 1'b1;
          else begin
            v = v * 64'd18 / f;
            if (src_sel == 2'd3) v = v / 2;
          end
        end
        if (e) v = 64'd0;
        else begin
          v = v / (64'(bus_div) + 1);
          v = v / (64'(io_div) + 1);
          if (id == 3'd2) v = v / (64'(tmr_div) + 1);
        end
      end
      3'd3: v = 64'd32768;
      3'd4: v = 64'd24000000;
      3'd5: v = 64'd3000000;
      default: v = 64'd0;
    endcase
    return {e, v[31:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic hs, input logic [1:0] s, input logic [5:0] p0,
                         input logic [5:0] p2, input logic [2:0] b, input logic [1:0] io,
                         input logic [5:0] t);
    pll_hi_sel = hs; src_sel = s; phase0_frac = p0; phase2_frac = p2;
    bus_div = b; io_div = io; tmr_div = t;
  endtask

  task automatic issue(input logic [2:0] id);
    for (int i = 0; i < WAIT_MAX && !req_ready; i++) @(negedge clk);
    req_valid = 1'b1;
    req_id    = id;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int i;
    for (i = 0; i < WAIT_MAX && !done; i++) @(negedge clk);
    if (!done) check({tag, " done"}, 32'd0, 32'd1);
  endtask

  task automatic run_case(input string tag, input logic [2:0] id);
    logic [32:0] exp;
    exp = model(id);
    issue(id);
    wait_done(tag);
    check(tag, freq, exp[31:0]);
    check({tag, " err"}, {31'd0, err}, {31'd0, exp[32]});
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 freq", freq, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_pll;
    set_cfg(1'b1, 2'd0, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    run_case("R2 x22", 3'd1);
    set_cfg(1'b0, 2'd0, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    run_case("R2 x20", 3'd1);
  endtask

  task automatic t_phase;
    set_cfg(1'b1, 2'd1, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    run_case("R3 sel1", 3'd1);
    set_cfg(1'b1, 2'd2, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    run_case("R3 sel2", 3'd1);
    set_cfg(1'b0, 2'd2, 6'd33, 6'd24, 3'd0, 2'd0, 6'd0);
    run_case("R3 odd", 3'd1);
  endtask

  task automatic t_half;
    set_cfg(1'b1, 2'd3, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    run_case("R4 half", 3'd1);
    set_cfg(1'b0, 2'd3, 6'd27, 6'd35, 3'd0, 2'd0, 6'd0);
    run_case("R4 odd", 3'd1);
  endtask

  task automatic t_chain;
    set_cfg(1'b1, 2'd0, 6'd27, 6'd24, 3'd3, 2'd1, 6'd0);
    run_case("R5 io a", 3'd1);
    set_cfg(1'b0, 2'd1, 6'd27, 6'd29, 3'd7, 2'd3, 6'd9);
    run_case("R5 io b", 3'd1);
  endtask

  task automatic t_tmr;
    set_cfg(1'b1, 2'd2, 6'd27, 6'd24, 3'd1, 2'd2, 6'd5);
    run_case("R6 tmr", 3'd2);
    set_cfg(1'b0, 2'd0, 6'd27, 6'd24, 3'd6, 2'd3, 6'd63);
    run_case("R6 max", 3'd2);
  endtask

  task automatic t_const;
    run_case("R7 low", 3'd3);
    run_case("R7 ref", 3'd4);
    run_case("R7 ref8", 3'd5);
  endtask

  task automatic t_none;
    run_case("R8 none", 3'd0);
    run_case("R8 id6", 3'd6);
    run_case("R8 id7", 3'd7);
  endtask

  task automatic t_zero;
    set_cfg(1'b1, 2'd1, 6'd27, 6'd0, 3'd0, 2'd0, 6'd0);
    run_case("R9 zero", 3'd1);
    set_cfg(1'b1, 2'd2, 6'd0, 6'd24, 3'd0, 2'd0, 6'd0);
    run_case("R9 zero p0", 3'd2);
    set_cfg(1'b1, 2'd0, 6'd0, 6'd0, 3'd1, 2'd0, 6'd0);
    run_case("R9 unselected", 3'd1);
  endtask

  task automatic t_busy;
    logic [32:0] exp;
    int          dones;
    set_cfg(1'b1, 2'd1, 6'd27, 6'd24, 3'd1, 2'd1, 6'd0);
    exp = model(3'd1);
    issue(3'd1);
    check("R10 busy ready", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1;
    req_id    = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R10 busy");
    check("R10 busy result", freq, exp[31:0]);
    check("R10 ready at done", {31'd0, req_ready}, 32'd1);
    dones = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R10 single done", 32'(dones), 32'd0);
    check("R13 hold", freq, exp[31:0]);
  endtask

  task automatic t_capture;
    logic [32:0] exp;
    set_cfg(1'b1, 2'd3, 6'd27, 6'd24, 3'd2, 2'd1, 6'd3);
    exp = model(3'd2);
    issue(3'd2);
    set_cfg(1'b0, 2'd2, 6'd1, 6'd5, 3'd0, 2'd3, 6'd0);
    wait_done("R11 capture");
    check("R11 capture", freq, exp[31:0]);
    @(negedge clk);
  endtask

  task automatic t_trunc;
    set_cfg(1'b1, 2'd1, 6'd27, 6'd1, 3'd0, 2'd0, 6'd0);
    run_case("R12 trunc", 3'd1);
    check("R12 value", freq, 32'd914065408);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_id    = 3'd0;
    set_cfg(1'b1, 2'd0, 6'd27, 6'd24, 3'd0, 2'd0, 6'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pll();
    t_phase();
    t_half();
    t_chain();
    t_tmr();
    t_const();
    t_none();
    t_zero();
    t_busy();
    t_capture();
    t_trunc();
    summary();
  end

endmodule